// File: doc/BRIEF.md
# Two-Way Processor Mailbox Queue

This block links two processors, side A and side B, through a pair of one-way word queues. Each side pushes words into its own outbound queue, and the opposite side pops them. Each side has a control/status word. Its queue flags are built from the same two queue counts, so one side's outbound flags always match the other side's inbound flags. A sticky error bit per side records a dropped send or an empty receive. A write of one to that bit clears it. A flush command empties the writer's outbound queue.

Each side has two single-cycle interrupt pulses:
- outbound queue empty;
- inbound queue holds data.

Both are evaluated on every control write and on queue events. The data paths use a valid/ready handshake with these back-pressure rules:
- `tx_ready` is high when the side is enabled and its outbound queue has room.
- A `tx_valid` while enabled and the queue is full is not stalled. The word is dropped and the error bit is set.
- `rx_valid` is high when the side is enabled and its inbound queue holds data. `rx_data` shows the head word while `rx_valid` is high, and 0 otherwise.
- A `rx_take` pops one word in the cycle where it is high.
- A take while enabled and the queue is empty sets the error bit.

The success of every access is decided from the queue state before the clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: Each direction holds 16 words of 32 bits. Words are received in the order sent, including after the pointers wrap past the 16th slot.
- R2: A send while the sender's outbound queue holds 16 words is dropped and sets the sender's error bit (bit 14). The queue content is unchanged.
- R3: A take while the inbound queue is empty shows `rx_data` = 0 and sets the taker's error bit (bit 14).
- R4: While a side's enable (bit 15) is 0, its sends and takes have no effect on either queue or on its error bit. Its `tx_ready` and `rx_valid` are 0 and its `rx_data` is 0.
- R5: Status layout: bit 0 outbound empty, bit 1 outbound full (16 words), bit 8 inbound empty, bit 9 inbound full. A side's bits 0/1 equal the other side's bits 8/9. Status reflects an access one cycle after its clock edge.
- R6: A successful send clears the error bit of both sides.
- R7: A control write with bit 14 = 1 clears that side's error bit.
- R8: A control write with bit 3 = 1 (flush) empties that side's outbound queue. The writer's bit 0 and the peer's bit 8 read 1, and both full bits read 0.
- R9: After a control write, the side's `irq_tx_empty` pulses if bit 2 is set and its outbound queue is empty. Its `irq_rx_nempty` pulses if bit 10 is set and its inbound queue is not empty.
- R10: A successful send pulses the receiver's `irq_rx_nempty` when the receiver's bit 10 is set. A take that drains a queue pulses the sender's `irq_tx_empty` when the sender's bit 2 is set.
- R11: After reset both queues are empty, each status reads 0x0101, and no interrupt is active.
- R12: A send by one side and a take by the other on the same non-empty queue in one cycle are both serviced. The word count stays the same.
- R13: Only bits 2, 10 and 15 are stored. Bit 3 reads 0, and all other non-flag bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_ctl_we | input | 1 | Side A control write strobe |
| a_ctl_wdata | input | 16 | Side A control write value |
| a_ctl_rdata | output | 16 | Side A control/status word |
| a_tx_valid | input | 1 | Side A send request |
| a_tx_data | input | 32 | Side A send word |
| a_tx_ready | output | 1 | Side A may send |
| a_rx_take | input | 1 | Side A pops its inbound queue |
| a_rx_valid | output | 1 | Side A inbound word available |
| a_rx_data | output | 32 | Side A inbound head word or 0 |
| a_irq_tx_empty | output | 1 | Side A outbound-empty pulse |
| a_irq_rx_nempty | output | 1 | Side A inbound-has-data pulse |
| b_ctl_we | input | 1 | Side B control write strobe |
| b_ctl_wdata | input | 16 | Side B control write value |
| b_ctl_rdata | output | 16 | Side B control/status word |
| b_tx_valid | input | 1 | Side B send request |
| b_tx_data | input | 32 | Side B send word |
| b_tx_ready | output | 1 | Side B may send |
| b_rx_take | input | 1 | Side B pops its inbound queue |
| b_rx_valid | output | 1 | Side B inbound word available |
| b_rx_data | output | 32 | Side B inbound head word or 0 |
| b_irq_tx_empty | output | 1 | Side B outbound-empty pulse |
| b_irq_rx_nempty | output | 1 | Side B inbound-has-data pulse |

## Verification
The results arrive at three different times:
- `rx_data`, `rx_valid` and `tx_ready` are combinational from registered state. They are compared before the edge that consumes them.
- Status words and error bits change at the edge of the access. They are read at the falling edge that follows.
- Interrupt pulses are registered from the same edge. They are checked at that same falling edge and shown low one cycle later.

Every stimulus task drives inputs at a falling edge, crosses exactly one rising edge, and samples at the next falling edge. This keeps every expected value aligned with those latencies.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int CTL_W   = 16;
  localparam int B_TXE   = 0;
  localparam int B_TXF   = 1;
  localparam int B_SIE   = 2;
  localparam int B_FLUSH = 3;
  localparam int B_RXE   = 8;
  localparam int B_RXF   = 9;
  localparam int B_RIE   = 10;
  localparam int B_ERR   = 14;
  localparam int B_EN    = 15;
  localparam int NSIDE   = 2;

  typedef struct packed {
    logic en;
    logic sie;
    logic rie;
  } side_cfg_t;
endpackage

// File: rtl/ipc_queue.sv
module ipc_queue #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  input  logic             flush,
  output logic [WIDTH-1:0] head_data,
  output logic             empty,
  output logic             full,
  output logic             nxt_zero
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count, count_nxt;
  logic             push_eff, pop_eff;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign push_eff = push && !flush;
  assign pop_eff  = pop && !flush;

  always_comb begin
    if (flush) count_nxt = '0;
    else       count_nxt = count + CW'(push_eff) - CW'(pop_eff);
  end

  always_ff @(posedge clk) begin
    if (push_eff) store[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_eff) wr_ptr <= adv(wr_ptr);
        if (pop_eff)  rd_ptr <= adv(rd_ptr);
      end
      count <= count_nxt;
    end
  end

  assign head_data = store[rd_ptr];
  assign empty     = (count == '0);
  assign full      = (count == FULLC);
  assign nxt_zero  = (count_nxt == '0);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  p_simul_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !flush) |=> $stable(count));
endmodule

// File: rtl/ipc_side.sv
module ipc_side
  import ipc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             rx_take,
  output logic             rx_valid,
  input  logic             own_empty,
  input  logic             own_full,
  input  logic             own_nxt_zero,
  input  logic             peer_empty,
  input  logic             peer_full,
  input  logic             peer_nxt_zero,
  input  logic             peer_push,
  input  logic             peer_pop,
  input  logic             peer_flush,
  output logic             push,
  output logic             pop,
  output logic             flush,
  output logic             irq_tx_empty,
  output logic             irq_rx_nempty
);
  side_cfg_t cfg, cfg_n;
  logic      err, err_n;
  logic      ovf, unf, err_clr;
  logic      irq_tx_n, irq_rx_n;
  logic      unused_wbits;

  always_comb begin
    cfg_n = cfg;
    if (ctl_we) begin
      cfg_n.en  = ctl_wdata[B_EN];
      cfg_n.sie = ctl_wdata[B_SIE];
      cfg_n.rie = ctl_wdata[B_RIE];
    end
  end

  assign flush = ctl_we && ctl_wdata[B_FLUSH];
  assign push  = tx_valid && cfg.en && !own_full && !flush;
  assign pop   = rx_take && cfg.en && !peer_empty && !peer_flush;
  assign ovf   = tx_valid && cfg.en && own_full;
  assign unf   = rx_take && cfg.en && peer_empty;
  assign err_clr = (ctl_we && ctl_wdata[B_ERR]) || push || peer_push;

  always_comb begin
    if (ovf || unf)   err_n = 1'b1;
    else if (err_clr) err_n = 1'b0;
    else              err_n = err;
  end

  assign irq_tx_n = cfg_n.sie && own_nxt_zero && (ctl_we || peer_pop);
  assign irq_rx_n = cfg_n.rie && ((ctl_we && !peer_nxt_zero) || peer_push);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg           <= '0;
      err           <= 1'b0;
      irq_tx_empty  <= 1'b0;
      irq_rx_nempty <= 1'b0;
    end else begin
      cfg           <= cfg_n;
      err           <= err_n;
      irq_tx_empty  <= irq_tx_n;
      irq_rx_nempty <= irq_rx_n;
    end
  end

  assign tx_ready = cfg.en && !own_full;
  assign rx_valid = cfg.en && !peer_empty;

  always_comb begin
    ctl_rdata         = '0;
    ctl_rdata[B_TXE]  = own_empty;
    ctl_rdata[B_TXF]  = own_full;
    ctl_rdata[B_SIE]  = cfg.sie;
    ctl_rdata[B_RXE]  = peer_empty;
    ctl_rdata[B_RXF]  = peer_full;
    ctl_rdata[B_RIE]  = cfg.rie;
    ctl_rdata[B_ERR]  = err;
    ctl_rdata[B_EN]   = cfg.en;
  end

  assign unused_wbits = ^{ctl_wdata[13:11], ctl_wdata[9:4], ctl_wdata[1:0]};

  p_disabled_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> (!push && !pop));
  p_overflow_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && cfg.en && own_full) |=> err);
  p_underflow_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && cfg.en && peer_empty) |=> err);
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[B_ERR] && !tx_valid && !rx_take) |=> !err);
  p_irq_tx_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx_empty |-> (own_empty && cfg.sie));
  p_irq_rx_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_nempty |-> cfg.rie);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_ctl_we,
  input  logic [CTL_W-1:0]  a_ctl_wdata,
  output logic [CTL_W-1:0]  a_ctl_rdata,
  input  logic              a_tx_valid,
  input  logic [DATA_W-1:0] a_tx_data,
  output logic              a_tx_ready,
  input  logic              a_rx_take,
  output logic              a_rx_valid,
  output logic [DATA_W-1:0] a_rx_data,
  output logic              a_irq_tx_empty,
  output logic              a_irq_rx_nempty,
  input  logic              b_ctl_we,
  input  logic [CTL_W-1:0]  b_ctl_wdata,
  output logic [CTL_W-1:0]  b_ctl_rdata,
  input  logic              b_tx_valid,
  input  logic [DATA_W-1:0] b_tx_data,
  output logic              b_tx_ready,
  input  logic              b_rx_take,
  output logic              b_rx_valid,
  output logic [DATA_W-1:0] b_rx_data,
  output logic              b_irq_tx_empty,
  output logic              b_irq_rx_nempty
);
  logic              ctl_we    [NSIDE];
  logic [CTL_W-1:0]  ctl_wdata [NSIDE];
  logic [CTL_W-1:0]  ctl_rdata [NSIDE];
  logic              tx_valid  [NSIDE];
  logic [DATA_W-1:0] tx_data   [NSIDE];
  logic              tx_ready  [NSIDE];
  logic              rx_take   [NSIDE];
  logic              rx_valid  [NSIDE];
  logic [DATA_W-1:0] rx_data   [NSIDE];
  logic              irq_txe   [NSIDE];
  logic              irq_rxn   [NSIDE];
  logic              push_w    [NSIDE];
  logic              pop_w     [NSIDE];
  logic              flush_w   [NSIDE];
  logic [DATA_W-1:0] head_w    [NSIDE];
  logic              empty_w   [NSIDE];
  logic              full_w    [NSIDE];
  logic              nz_w      [NSIDE];

  assign ctl_we[0]    = a_ctl_we;
  assign ctl_wdata[0] = a_ctl_wdata;
  assign tx_valid[0]  = a_tx_valid;
  assign tx_data[0]   = a_tx_data;
  assign rx_take[0]   = a_rx_take;
  assign ctl_we[1]    = b_ctl_we;
  assign ctl_wdata[1] = b_ctl_wdata;
  assign tx_valid[1]  = b_tx_valid;
  assign tx_data[1]   = b_tx_data;
  assign rx_take[1]   = b_rx_take;

  assign a_ctl_rdata     = ctl_rdata[0];
  assign a_tx_ready      = tx_ready[0];
  assign a_rx_valid      = rx_valid[0];
  assign a_rx_data       = rx_data[0];
  assign a_irq_tx_empty  = irq_txe[0];
  assign a_irq_rx_nempty = irq_rxn[0];
  assign b_ctl_rdata     = ctl_rdata[1];
  assign b_tx_ready      = tx_ready[1];
  assign b_rx_valid      = rx_valid[1];
  assign b_rx_data       = rx_data[1];
  assign b_irq_tx_empty  = irq_txe[1];
  assign b_irq_rx_nempty = irq_rxn[1];

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam int P = NSIDE - 1 - g;

    ipc_queue #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_w[g]),
      .push_data (tx_data[g]),
      .pop       (pop_w[P]),
      .flush     (flush_w[g]),
      .head_data (head_w[g]),
      .empty     (empty_w[g]),
      .full      (full_w[g]),
      .nxt_zero  (nz_w[g])
    );

    ipc_side u_side (
      .clk           (clk),
      .rst_n         (rst_n),
      .ctl_we        (ctl_we[g]),
      .ctl_wdata     (ctl_wdata[g]),
      .ctl_rdata     (ctl_rdata[g]),
      .tx_valid      (tx_valid[g]),
      .tx_ready      (tx_ready[g]),
      .rx_take       (rx_take[g]),
      .rx_valid      (rx_valid[g]),
      .own_empty     (empty_w[g]),
      .own_full      (full_w[g]),
      .own_nxt_zero  (nz_w[g]),
      .peer_empty    (empty_w[P]),
      .peer_full     (full_w[P]),
      .peer_nxt_zero (nz_w[P]),
      .peer_push     (push_w[P]),
      .peer_pop      (pop_w[P]),
      .peer_flush    (flush_w[P]),
      .push          (push_w[g]),
      .pop           (pop_w[g]),
      .flush         (flush_w[g]),
      .irq_tx_empty  (irq_txe[g]),
      .irq_rx_nempty (irq_rxn[g])
    );

    assign rx_data[g] = rx_valid[g] ? head_w[P] : '0;
  end

  p_rx_zero_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !a_rx_valid |-> (a_rx_data == '0));
  p_drain_sets_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_rx_take && b_rx_valid && !a_tx_valid && a_ctl_rdata[ipc_pkg::B_TXE] == 1'b0
     && nz_w[0]) |=> b_ctl_rdata[ipc_pkg::B_RXE]);
endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_ctl_we, b_ctl_we;
  logic [15:0] a_ctl_wdata, b_ctl_wdata, a_ctl_rdata, b_ctl_rdata;
  logic        a_tx_valid, b_tx_valid, a_tx_ready, b_tx_ready;
  logic [31:0] a_tx_data, b_tx_data, a_rx_data, b_rx_data;
  logic        a_rx_take, b_rx_take, a_rx_valid, b_rx_valid;
  logic        a_irq_tx_empty, a_irq_rx_nempty, b_irq_tx_empty, b_irq_rx_nempty;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ipc_mailbox dut (
    .clk(clk), .rst_n(rst_n),
    .a_ctl_we(a_ctl_we), .a_ctl_wdata(a_ctl_wdata), .a_ctl_rdata(a_ctl_rdata),
    .a_tx_valid(a_tx_valid), .a_tx_data(a_tx_data), .a_tx_ready(a_tx_ready),
    .a_rx_take(a_rx_take), .a_rx_valid(a_rx_valid), .a_rx_data(a_rx_data),
    .a_irq_tx_empty(a_irq_tx_empty), .a_irq_rx_nempty(a_irq_rx_nempty),
    .b_ctl_we(b_ctl_we), .b_ctl_wdata(b_ctl_wdata), .b_ctl_rdata(b_ctl_rdata),
    .b_tx_valid(b_tx_valid), .b_tx_data(b_tx_data), .b_tx_ready(b_tx_ready),
    .b_rx_take(b_rx_take), .b_rx_valid(b_rx_valid), .b_rx_data(b_rx_data),
    .b_irq_tx_empty(b_irq_tx_empty), .b_irq_rx_nempty(b_irq_rx_nempty)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=<20000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] st(input int s);
    return (s == 0) ? a_ctl_rdata : b_ctl_rdata;
  endfunction

  task automatic ctl(input int s, input logic [15:0] v);
    if (s == 0) begin a_ctl_we = 1'b1; a_ctl_wdata = v; end
    else        begin b_ctl_we = 1'b1; b_ctl_wdata = v; end
    step();
    a_ctl_we = 1'b0; b_ctl_we = 1'b0;
  endtask

  task automatic send(input int s, input logic [31:0] d);
    if (s == 0) begin a_tx_valid = 1'b1; a_tx_data = d; end
    else        begin b_tx_valid = 1'b1; b_tx_data = d; end
    step();
    a_tx_valid = 1'b0; b_tx_valid = 1'b0;
  endtask

  task automatic recv(input int s, input logic [31:0] exp, input string tag);
    chk(tag, (s == 0) ? a_rx_data : b_rx_data, exp);
    if (s == 0) a_rx_take = 1'b1; else b_rx_take = 1'b1;
    step();
    a_rx_take = 1'b0; b_rx_take = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 a status", a_ctl_rdata, 16'h0101);
    chk("R11 b status", b_ctl_rdata, 16'h0101);
    chk("R11 irqs", {a_irq_tx_empty, a_irq_rx_nempty, b_irq_tx_empty, b_irq_rx_nempty}, 0);
  endtask

  task automatic t_ctl_bits();
    ctl(0, 16'hFFFF);
    chk("R13 stored bits", st(0), 16'h8505);
    chk("R9 tx empty irq on write", a_irq_tx_empty, 1);
    chk("R9 no rx irq when empty", a_irq_rx_nempty, 0);
    step();
    chk("R9 irq is a pulse", a_irq_tx_empty, 0);
    ctl(0, 16'h8000);
    ctl(1, 16'h8000);
    chk("R13 a enable only", st(0), 16'h8101);
    chk("R13 b enable only", st(1), 16'h8101);
  endtask

  task automatic t_order();
    for (int i = 0; i < 16; i++) send(0, 32'hA000_0000 + i);
    chk("R5 a full flags", st(0), 16'h8102);
    chk("R5 b mirrored flags", st(1), 16'h8201);
    chk("R1 tx_ready low when full", a_tx_ready, 0);
    chk("R1 rx_valid", b_rx_valid, 1);
    for (int i = 0; i < 16; i++) recv(1, 32'hA000_0000 + i, "R1 order");
    chk("R5 drained flags", st(0), 16'h8101);
    for (int i = 16; i < 20; i++) send(0, 32'hA000_0000 + i);
    for (int i = 16; i < 20; i++) recv(1, 32'hA000_0000 + i, "R1 wrap order");
    chk("R1 empty after wrap", b_rx_valid, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 16; i++) send(0, 32'hB000_0000 + i);
    send(0, 32'hDEAD_BEEF);
    chk("R2 overflow error", st(0), 16'hC102);
    chk("R2 peer unaffected", st(1), 16'h8201);
    for (int i = 0; i < 16; i++) recv(1, 32'hB000_0000 + i, "R2 content intact");
    chk("R2 extra word dropped", b_rx_valid, 0);
  endtask

  task automatic t_underflow();
    recv(1, 32'h0, "R3 empty data zero");
    chk("R3 underflow error", st(1), 16'hC101);
  endtask

  task automatic t_send_clears();
    send(0, 32'h0000_1234);
    chk("R6 sender error cleared", st(0), 16'h8100);
    chk("R6 receiver error cleared", st(1), 16'h8001);
    recv(1, 32'h0000_1234, "R6 word");
  endtask

  task automatic t_w1c();
    recv(0, 32'h0, "R3 a empty data zero");
    chk("R7 error set", st(0), 16'hC101);
    ctl(0, 16'hC000);
    chk("R7 write one clears", st(0), 16'h8101);
  endtask

  task automatic t_irq();
    ctl(1, 16'h8400);
    chk("R9 no rx irq when empty", b_irq_rx_nempty, 0);
    send(0, 32'h55);
    chk("R10 rx irq on send", b_irq_rx_nempty, 1);
    ctl(0, 16'h8004);
    chk("R9 no tx irq when not empty", a_irq_tx_empty, 0);
    recv(1, 32'h55, "R10 word");
    chk("R10 tx irq on drain", a_irq_tx_empty, 1);
    send(0, 32'h66);
    step();
    chk("R10 rx irq pulse ends", b_irq_rx_nempty, 0);
    ctl(1, 16'h8400);
    chk("R9 rx irq on write", b_irq_rx_nempty, 1);
    recv(1, 32'h66, "R10 word2");
    chk("R10 tx irq on drain2", a_irq_tx_empty, 1);
    ctl(0, 16'h8000);
    ctl(1, 16'h8000);
  endtask

  task automatic t_flush();
    send(0, 32'h1);
    send(0, 32'h2);
    send(0, 32'h3);
    ctl(0, 16'h8008);
    chk("R8 writer empty", st(0), 16'h8101);
    chk("R8 peer empty", st(1), 16'h8101);
    chk("R8 nothing to take", b_rx_valid, 0);
  endtask

  task automatic t_disable();
    send(1, 32'h77);
    chk("R5 a sees inbound", st(0), 16'h8001);
    ctl(0, 16'h0000);
    chk("R4 disabled status", st(0), 16'h0001);
    chk("R4 tx_ready low", a_tx_ready, 0);
    chk("R4 rx_valid low", a_rx_valid, 0);
    send(0, 32'h99);
    chk("R4 send ignored", st(1), 16'h8100);
    recv(0, 32'h0, "R4 data zero when disabled");
    chk("R4 take ignored no error", st(0), 16'h0001);
    chk("R4 peer still holds word", st(1), 16'h8100);
    ctl(0, 16'h8000);
    recv(0, 32'h77, "R4 word kept");
  endtask

  task automatic t_simul();
    send(0, 32'h101);
    send(0, 32'h202);
    chk("R12 head", b_rx_data, 32'h101);
    a_tx_valid = 1'b1; a_tx_data = 32'h303; b_rx_take = 1'b1;
    step();
    a_tx_valid = 1'b0; b_rx_take = 1'b0;
    recv(1, 32'h202, "R12 second");
    recv(1, 32'h303, "R12 third");
    chk("R12 exactly two left", b_rx_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    a_ctl_we = 0; b_ctl_we = 0; a_ctl_wdata = 0; b_ctl_wdata = 0;
    a_tx_valid = 0; b_tx_valid = 0; a_tx_data = 0; b_tx_data = 0;
    a_rx_take = 0; b_rx_take = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_ctl_bits();
    t_order();
    t_overflow();
    t_underflow();
    t_send_clears();
    t_w1c();
    t_irq();
    t_flush();
    t_disable();
    t_simul();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule